// File: doc/BRIEF.md
# Glitch-Free Clock Output Stop Controller

This block sits between a set of already-divided clock sources and the output pads of a clock generator. Each output is switched on or off without ever producing a shortened high pulse. Every source is treated as a level sampled by the master clock. An enable is allowed to change only at a master edge where its source is low, so each output either passes a complete high phase or none of it.

Two active-low stop inputs drive the gating, and both pass through a two-flop synchronizer. The global stop halts the gated CPU clock, the interrupt-controller reference clock and the twelve gated memory clocks. The PCI-only stop is captured again on each rising edge of the free-running PCI source, and it holds the five gated PCI clocks low. Free-running copies of the CPU, PCI and memory clocks ignore both stops. A per-output enable word can hold any single output low on top of the stops. A three-state request removes the output enable of every pad.

Top module: `clkstop_ctrl`

## Requirements
- R1: While reset is asserted, every clock output and the pad enable `oe_o` are 0.
- R2: Every output high pulse is exactly as long as its source high phase, with no shortened pulse at a stop or a restart. In the test setup these phases are 1 master cycle for CPU, 2 for memory and interrupt-controller clocks, and 4 for PCI.
- R3: After `stop_n` falls, the gated CPU output still produces a high in one of the first two master cycles. It is low from the third master edge on if its source is low at that edge. All globally stopped outputs stay low once each has passed one source-low edge after synchronization.
- R4: After `stop_n` rises, the gated CPU output restarts within 6 master cycles, and the memory and interrupt-controller outputs restart within 10, each with a complete first pulse.
- R5: `stop_n` has no effect on `cpu_free_o`, `pci_free_o`, `sdr_free_o` or the gated PCI outputs.
- R6: The synchronized PCI stop is latched only at a rising edge of `pci_src`. A low pulse on `pci_stop_n` that has cleared the synchronizer before the next PCI rising edge is ignored.
- R7: While `pci_stop_n` is low, all five `pci_gated_o` bits are held at 0 within 17 master cycles. `pci_free_o`, `cpu_free_o` and `cpu_gated_o` keep toggling.
- R8: An enable bit of 0 in `out_en_cfg` holds its output low whatever the stop inputs do. The bit order is: [0] free CPU, [1] gated CPU, [2] free PCI, [3+i] gated PCI i, [3+N_PCI] free memory, [4+N_PCI+j] gated memory j, and [4+N_PCI+N_SDR] interrupt-controller clock.
- R9: `tristate` high drives `oe_o` to 0 one master cycle later, and the clock outputs keep running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_src | input | 1 | Divided CPU clock source |
| pci_src | input | 1 | Divided PCI clock source |
| sdr_src | input | 1 | Memory clock source |
| apic_src | input | 1 | Interrupt-controller reference source |
| stop_n | input | 1 | Global stop, active low, asynchronous |
| pci_stop_n | input | 1 | PCI group stop, active low, asynchronous |
| out_en_cfg | input | 5+N_PCI+N_SDR | Per-output enable word (see R8) |
| tristate | input | 1 | Request to float all pads |
| cpu_free_o | output | 1 | Free-running CPU clock |
| cpu_gated_o | output | 1 | Gated CPU clock |
| pci_free_o | output | 1 | Free-running PCI clock |
| pci_gated_o | output | N_PCI | Gated PCI clocks |
| sdr_free_o | output | 1 | Free-running memory clock |
| sdr_gated_o | output | N_SDR | Gated memory clocks |
| apic_o | output | 1 | Gated interrupt-controller clock |
| oe_o | output | 1 | Pad output enable |

## Verification
The hardest case to reach is a PCI stop pulse that passes fully through the synchronizer yet never lines up with a PCI rising edge. That pulse must leave the gated PCI clocks untouched. The bench reads the phase of its own source divider, waits for the negedge on which the PCI source rises, and drives a three-cycle stop pulse right after the capturing edge. It then counts PCI high samples over four full periods. Stops and releases are also driven at arbitrary phases while a monitor measures the width of every pulse, so a cut or partial pulse is caught wherever it appears.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;
  // Enable-word layout: fcpu, gcpu, fpci, gpci[np], fsdr, gsdr[ns], apic
  function automatic int cfg_width(input int np, input int ns);
    return 5 + np + ns;
  endfunction
  localparam int IDX_CPU_F = 0;
  localparam int IDX_CPU_G = 1;
  localparam int IDX_PCI_F = 2;
  function automatic int idx_pci(input int i);
    return 3 + i;
  endfunction
  function automatic int idx_sdr_f(input int np);
    return 3 + np;
  endfunction
  function automatic int idx_sdr(input int np, input int j);
    return 4 + np + j;
  endfunction
  function automatic int idx_apic(input int np, input int ns);
    return 4 + np + ns;
  endfunction
endpackage

// File: rtl/clkstop_sync.sv
module clkstop_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], d};
  end
  assign q = chain[STAGES-1];
endmodule

// File: rtl/clkstop_gate.sv
module clkstop_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic src,
  input  logic want,
  output logic q
);
  logic en_q;
  // The enable may only move while the source is low, so no high phase is cut
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      q    <= 1'b0;
    end else begin
      if (!src) en_q <= want;
      q <= src & en_q;
    end
  end
endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl
  import clkstop_pkg::*;
#(
  parameter int N_PCI       = 5,
  parameter int N_SDR       = 12,
  parameter int SYNC_STAGES = 2,
  localparam int CFG_W      = 5 + N_PCI + N_SDR
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_src,
  input  logic             pci_src,
  input  logic             sdr_src,
  input  logic             apic_src,
  input  logic             stop_n,
  input  logic             pci_stop_n,
  input  logic [CFG_W-1:0] out_en_cfg,
  input  logic             tristate,
  output logic             cpu_free_o,
  output logic             cpu_gated_o,
  output logic             pci_free_o,
  output logic [N_PCI-1:0] pci_gated_o,
  output logic             sdr_free_o,
  output logic [N_SDR-1:0] sdr_gated_o,
  output logic             apic_o,
  output logic             oe_o
);
  // Named internal events, visible to the bound checker
  logic stop_s;
  logic pci_stop_s;
  logic pci_d;
  logic pci_rise;
  logic pci_hold;

  clkstop_sync #(.STAGES(SYNC_STAGES)) u_sync_glb (
    .clk(clk), .rst_n(rst_n), .d(stop_n), .q(stop_s));
  clkstop_sync #(.STAGES(SYNC_STAGES)) u_sync_pci (
    .clk(clk), .rst_n(rst_n), .d(pci_stop_n), .q(pci_stop_s));

  assign pci_rise = pci_src & ~pci_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pci_d    <= 1'b0;
      pci_hold <= 1'b1;
      oe_o     <= 1'b0;
    end else begin
      pci_d <= pci_src;
      if (pci_rise) pci_hold <= pci_stop_s;
      oe_o <= ~tristate;
    end
  end

  clkstop_gate u_cpu_f (.clk(clk), .rst_n(rst_n), .src(cpu_src),
    .want(out_en_cfg[IDX_CPU_F]), .q(cpu_free_o));
  clkstop_gate u_cpu_g (.clk(clk), .rst_n(rst_n), .src(cpu_src),
    .want(stop_s & out_en_cfg[IDX_CPU_G]), .q(cpu_gated_o));
  clkstop_gate u_pci_f (.clk(clk), .rst_n(rst_n), .src(pci_src),
    .want(out_en_cfg[IDX_PCI_F]), .q(pci_free_o));
  clkstop_gate u_sdr_f (.clk(clk), .rst_n(rst_n), .src(sdr_src),
    .want(out_en_cfg[idx_sdr_f(N_PCI)]), .q(sdr_free_o));
  clkstop_gate u_apic (.clk(clk), .rst_n(rst_n), .src(apic_src),
    .want(stop_s & out_en_cfg[idx_apic(N_PCI, N_SDR)]), .q(apic_o));

  for (genvar i = 0; i < N_PCI; i++) begin : g_pci
    clkstop_gate u_g (.clk(clk), .rst_n(rst_n), .src(pci_src),
      .want(pci_hold & out_en_cfg[idx_pci(i)]), .q(pci_gated_o[i]));
  end

  for (genvar j = 0; j < N_SDR; j++) begin : g_sdr
    clkstop_gate u_g (.clk(clk), .rst_n(rst_n), .src(sdr_src),
      .want(stop_s & out_en_cfg[idx_sdr(N_PCI, j)]), .q(sdr_gated_o[j]));
  end
endmodule

// File: rtl/clkstop_chk.sv
module clkstop_chk (
  input logic clk,
  input logic rst_n,
  input logic stop_n,
  input logic tristate,
  input logic cfg_cpu_g,
  input logic cpu_src,
  input logic cpu_gated_o,
  input logic apic_src,
  input logic apic_o,
  input logic pci_src,
  input logic pci_g0,
  input logic pci_rise,
  input logic pci_hold,
  input logic oe_o
);
  logic [2:0] stop_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              stop_cnt <= '0;
    else if (stop_n)         stop_cnt <= '0;
    else if (stop_cnt != 3'd7) stop_cnt <= stop_cnt + 3'd1;
  end

  AST_CPU_STOP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_cnt >= 3'd3 && !stop_n && !cpu_src) |=> !cpu_gated_o); // R3
  AST_APIC_STOP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_cnt >= 3'd3 && !stop_n && !apic_src) |=> !apic_o); // R3
  AST_WHOLE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pci_g0) |-> (!$past(pci_src) && $past(pci_src, 2))); // R2
  AST_WHOLE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pci_g0) |-> ($past(pci_src) && !$past(pci_src, 2))); // R2
  AST_DISABLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_cpu_g && !cpu_src) |=> !cpu_gated_o); // R8
  AST_PCI_EDGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !pci_rise |=> $stable(pci_hold)); // R6
  AST_TRISTATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    tristate |=> !oe_o); // R9
endmodule

bind clkstop_ctrl clkstop_chk u_chk (
  .clk(clk), .rst_n(rst_n), .stop_n(stop_n), .tristate(tristate),
  .cfg_cpu_g(out_en_cfg[1]), .cpu_src(cpu_src), .cpu_gated_o(cpu_gated_o),
  .apic_src(apic_src), .apic_o(apic_o), .pci_src(pci_src),
  .pci_g0(pci_gated_o[0]), .pci_rise(pci_rise), .pci_hold(pci_hold),
  .oe_o(oe_o));

// File: tb/test_clkstop_ctrl.sv
module test_clkstop_ctrl;
  localparam int NP = 5;
  localparam int NS = 12;
  localparam int CW = 5 + NP + NS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] cyc = '0;
  logic stop_n = 1'b1, pci_stop_n = 1'b1, tristate = 1'b0;
  logic [CW-1:0] cfg = '1;
  logic cpu_free, cpu_g, pci_free, sdr_free, apic, oe;
  logic [NP-1:0] pci_g;
  logic [NS-1:0] sdr_g;
  int checks = 0, fails = 0;
  bit mon_on = 1'b0;

  always #4 clk = ~clk;
  always @(negedge clk) cyc <= cyc + 8'd1;

  clkstop_ctrl i_clkstop_ctrl (
    .clk(clk), .rst_n(rst_n), .cpu_src(cyc[0]), .pci_src(cyc[2]),
    .sdr_src(cyc[1]), .apic_src(cyc[1]), .stop_n(stop_n),
    .pci_stop_n(pci_stop_n), .out_en_cfg(cfg), .tristate(tristate),
    .cpu_free_o(cpu_free), .cpu_gated_o(cpu_g), .pci_free_o(pci_free),
    .pci_gated_o(pci_g), .sdr_free_o(sdr_free), .sdr_gated_o(sdr_g),
    .apic_o(apic), .oe_o(oe));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Pulse-width monitor: every completed high pulse is compared with its source phase
  int run [7];
  int wexp [7] = '{1, 1, 4, 4, 2, 2, 2};
  always @(negedge clk) begin
    logic [6:0] s;
    s = {apic, sdr_free, sdr_g[0], pci_free, pci_g[0], cpu_free, cpu_g};
    if (mon_on) begin
      for (int k = 0; k < 7; k++) begin
        if (s[k]) run[k]++;
        else if (run[k] != 0) begin
          chk(run[k] == wexp[k], "R2 pulse width", run[k], wexp[k]);
          run[k] = 0;
        end
      end
    end
  end

  // High-sample counters over a window
  int h_cpu_g, h_cpu_f, h_pci_f, h_sdr_f, h_sdr_g, h_apic;
  int h_pci [NP];
  task automatic window(input int n);
    h_cpu_g = 0; h_cpu_f = 0; h_pci_f = 0; h_sdr_f = 0; h_sdr_g = 0; h_apic = 0;
    for (int k = 0; k < NP; k++) h_pci[k] = 0;
    repeat (n) begin
      @(negedge clk); #1;
      h_cpu_g += int'(cpu_g); h_cpu_f += int'(cpu_free); h_pci_f += int'(pci_free);
      h_sdr_f += int'(sdr_free); h_sdr_g += int'(|sdr_g); h_apic += int'(apic);
      for (int k = 0; k < NP; k++) h_pci[k] += int'(pci_g[k]);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    chk(1'b0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int first;
    step(4); #1;
    // R1: reset state
    chk({cpu_free, cpu_g, pci_free, pci_g, sdr_free, sdr_g, apic} == '0, "R1 outputs", 1, 0);
    chk(oe == 1'b0, "R1 oe", int'(oe), 0);
    @(negedge clk); rst_n = 1'b1;
    step(8); mon_on = 1'b1;
    window(16);
    chk(oe == 1'b1, "R9 oe after reset", int'(oe), 1);
    chk(h_cpu_g == 8 && h_pci[4] == 8 && h_apic == 8, "R2 running", h_cpu_g, 8);

    // R3: global stop
    @(negedge clk); stop_n = 1'b0;
    window(2);
    chk(h_cpu_g >= 1, "R3 minimum latency", h_cpu_g, 1);
    step(4);
    window(24);
    chk(h_cpu_g == 0, "R3 cpu stopped", h_cpu_g, 0);
    chk(h_sdr_g == 0, "R3 sdram stopped", h_sdr_g, 0);
    chk(h_apic == 0, "R3 apic stopped", h_apic, 0);
    chk(h_cpu_f == 12 && h_sdr_f == 12, "R5 free cpu/sdram run", h_cpu_f, 12);
    chk(h_pci_f == 12 && h_pci[0] == 12, "R5 pci unaffected", h_pci[0], 12);
    // R4: restart
    @(negedge clk); stop_n = 1'b1;
    first = -1;
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk); #1;
      if (cpu_g && first < 0) first = k;
    end
    chk(first >= 1 && first <= 6, "R4 cpu restart", first, 6);
    window(8);
    chk(h_sdr_g == 4 && h_apic == 4, "R4 sdram/apic restart", h_apic, 4);

    // R7: PCI stop
    @(negedge clk); pci_stop_n = 1'b0;
    step(17);
    window(24);
    for (int k = 0; k < NP; k++) chk(h_pci[k] == 0, "R7 pci gated low", h_pci[k], 0);
    chk(h_pci_f == 12, "R7 pci free runs", h_pci_f, 12);
    chk(h_cpu_f == 12 && h_cpu_g == 12, "R7 cpu runs", h_cpu_g, 12);
    @(negedge clk); pci_stop_n = 1'b1;
    step(24);
    window(16);
    chk(h_pci[0] == 8 && h_pci[4] == 8, "R7 pci restart", h_pci[0], 8);

    // R6: a short stop pulse between PCI rising edges is ignored
    do begin @(negedge clk); #1; end while (cyc[2:0] != 3'd4);
    @(negedge clk); pci_stop_n = 1'b0;
    step(3); pci_stop_n = 1'b1;
    window(32);
    for (int k = 0; k < NP; k++) chk(h_pci[k] == 16, "R6 short pulse ignored", h_pci[k], 16);

    // R8: per-output disables
    @(negedge clk);
    cfg[1] = 1'b0; cfg[3 + 2] = 1'b0; cfg[3 + NP] = 1'b0; cfg[4 + NP + NS] = 1'b0;
    step(8);
    window(16);
    chk(h_cpu_g == 0, "R8 cpu gated disabled", h_cpu_g, 0);
    chk(h_pci[2] == 0 && h_pci[1] == 8, "R8 pci2 disabled", h_pci[2], 0);
    chk(h_sdr_f == 0, "R8 sdram free disabled", h_sdr_f, 0);
    chk(h_apic == 0, "R8 apic disabled with stop high", h_apic, 0);
    @(negedge clk); cfg = '1;
    step(8);
    window(16);
    chk(h_cpu_g == 8 && h_pci[2] == 8 && h_apic == 8, "R8 re-enabled", h_cpu_g, 8);

    // R9: three-state request
    @(negedge clk); tristate = 1'b1;
    @(negedge clk); #1;
    chk(oe == 1'b0, "R9 oe dropped", int'(oe), 0);
    window(8);
    chk(h_cpu_f == 4, "R9 clocks keep running", h_cpu_f, 4);
    @(negedge clk); tristate = 1'b0;
    @(negedge clk); #1;
    chk(oe == 1'b1, "R9 oe restored", int'(oe), 1);

    step(4);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule